// File: doc/BRIEF.md
# Double-to-Single Store Narrowing Converter

This block takes a 64-bit double-precision register image and narrows it to a 32-bit single-precision word, ready for a floating-point store. The block compares the biased exponent of the double against fixed thresholds to pick one of three paths:

- **Direct path.** Values that fit a normal single, along with zero, infinity and NaN, are formed by picking bits straight out of the double, with no rounding.
- **Subnormal path.** Values that fall into the single subnormal range have their significand shifted right, in one step, by a barrel shifter. The result is truncated.
- **Underflow path.** Anything smaller becomes a signed zero.

Each accepted input produces one registered result, with a valid strobe, one clock later. A store pipeline drives `in_valid` together with `in_dword` and takes `out_word` when `out_valid` is high. The output word holds its value between accepted inputs. Rounding modes, exception flags and the memory write itself are handled elsewhere.

Bit numbering is big-endian. Big-endian bit 0 is the most significant bit, so big-endian bit k of the 64-bit input is `in_dword[63-k]`. The input fields are:
- sign: `in_dword[63]`
- biased exponent E: `in_dword[62:52]`
- fraction: `in_dword[51:0]`

Top module: `fp_narrow_store`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `out_valid` is 0 and `out_word` is 0.
- R2: `out_valid` is high in exactly the cycle after a rising clock edge at which `in_valid` was high.
- R3: If E > 896, then on the next edge `out_word[31:30]` becomes `in_dword[63:62]` and `out_word[29:0]` becomes `in_dword[58:29]`. This is a plain bit selection with no rounding, and it covers infinity and NaN (E = 2047).
- R4: If `in_dword[62:0]` is all zero, the output is a zero with the input's sign: `{in_dword[63], 31'b0}`.
- R5: If 874 ≤ E ≤ 896, the output is built as follows:
  - `out_word[31]` is the input sign.
  - `out_word[30:23]` is zero.
  - `out_word[22:0]` is bits [51:29] of the 53-bit value `{1'b1, fraction}` shifted right by (897 − E), with the dropped bits truncated.
- R6: The subnormal path is correct at both ends of its range. At E = 896 (shift of 1), the output fraction is `{1'b1, in_dword[51:30]}`. At E = 874 (shift of 23), the output fraction is 23'h000001.
- R7: If 0 ≤ E < 874 and `in_dword[62:0]` is not all zero, the output is `{sign, 31'b0}`. This includes double subnormals (E = 0).
- R8: In a cycle where `in_valid` is low at the edge, `out_word` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present this cycle |
| in_dword | input | 64 | Double-precision image |
| out_valid | output | 1 | Result present this cycle |
| out_word | output | 32 | Single-precision result |

## Verification
Two things can happen at the same clock edge: a new result on one path is registered while the previous result, from a different path, leaves the output. The bench provokes this with back-to-back inputs that alternate between direct, subnormal, underflow and zero values. It also mixes in idle cycles. An idle cycle must leave the previous word in place (R8) while `out_valid` drops (R2). Each cycle is judged against a behavioural model that denormalizes by stepping the shift one position at a time.

// File: rtl/fp_narrow_store.sv
module fp_narrow_store (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_dword,
  output logic        out_valid,
  output logic [31:0] out_word
);
  localparam logic [10:0] DIRECT_ABOVE = 11'd896;
  localparam logic [10:0] SUB_FLOOR    = 11'd874;
  localparam logic [10:0] SHIFT_BASE   = 11'd897;

  logic        sgn;
  logic [10:0] bexp;
  logic        is_direct, is_sub;
  logic [10:0] shamt_full;
  logic [52:0] sig_shifted;
  logic [31:0] word_next;

  assign sgn         = in_dword[63];
  assign bexp        = in_dword[62:52];
  assign is_direct   = (bexp > DIRECT_ABOVE) || (in_dword[62:0] == 63'd0);
  assign is_sub      = (bexp >= SUB_FLOOR) && (bexp <= DIRECT_ABOVE);
  assign shamt_full  = SHIFT_BASE - bexp;
  assign sig_shifted = {1'b1, in_dword[51:0]} >> shamt_full[4:0];

  always_comb begin
    if (is_direct)
      word_next = {in_dword[63:62], in_dword[58:29]};
    else if (is_sub)
      word_next = {sgn, 8'd0, sig_shifted[51:29]};
    else
      word_next = {sgn, 31'd0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= 32'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= word_next;
    end
  end
endmodule

module fp_narrow_store_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_dword,
  input logic        out_valid,
  input logic [31:0] out_word
);
  logic [10:0] e;
  assign e = in_dword[62:52];

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_direct_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && e > 11'd896) |=> out_word == {$past(in_dword[63:62]), $past(in_dword[58:29])});
  assert_zero_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_dword[62:0] == 63'd0) |=> out_word == {$past(in_dword[63]), 31'd0});
  assert_sub_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && e >= 11'd874 && e <= 11'd896) |=>
      (out_word[30:23] == 8'd0 && out_word[31] == $past(in_dword[63]) && out_word[22:0] != 23'd0));
  assert_low_exp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && e < 11'd874 && in_dword[62:0] != 63'd0) |=> out_word[30:0] == 31'd0);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word));
endmodule

bind fp_narrow_store fp_narrow_store_chk u_chk (.*);

// File: tb/fp_narrow_store_bench.sv
module fp_narrow_store_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [63:0] in_dword = 64'd0;
  logic out_valid;
  logic [31:0] out_word;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  logic        m_valid = 1'b0;
  logic [31:0] m_word = 32'd0;
  string       m_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_narrow_store u_fp_narrow_store (.*);

  function automatic logic [31:0] model(input logic [63:0] d);
    int x;
    int e;
    logic [52:0] f;
    e = int'(d[62:52]);
    if (e > 896 || d[62:0] == 63'd0) return {d[63:62], d[58:29]};
    if (e >= 874) begin
      x = e - 1023;
      f = {1'b1, d[51:0]};
      while (x < -126) begin
        f = {1'b0, f[52:1]};
        x = x + 1;
      end
      return {d[63], 8'd0, f[51:29]};
    end
    return {d[63], 31'd0};
  endfunction

  function automatic string tag_of(input logic [63:0] d);
    int e;
    e = int'(d[62:52]);
    if (d[62:0] == 63'd0) return "R4";
    if (e > 896) return "R3";
    if (e == 896 || e == 874) return "R6";
    if (e >= 874) return "R5";
    return "R7";
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      m_valid <= 1'b0; m_word <= 32'd0; m_tag <= "R1";
    end else begin
      m_valid <= in_valid;
      if (in_valid) begin
        m_word <= model(in_dword); m_tag <= tag_of(in_dword);
      end else m_tag <= "R8";
    end
  end

  always @(negedge clk) begin
    n_cmp++;
    if (out_valid !== m_valid) begin
      n_bad++;
      $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, m_valid);
    end
    n_cmp++;
    if (out_word !== m_word) begin
      n_bad++;
      $display("FAIL %s out_word actual=%08h expected=%08h", m_tag, out_word, m_word);
    end
  end

  task automatic send(input logic [63:0] d);
    @(posedge clk); #1;
    in_valid = 1'b1; in_dword = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0; in_dword = {$urandom, $urandom};
    end
  endtask

  function automatic logic [63:0] mk(input logic s, input int e, input logic [51:0] f);
    return {s, 11'(e), f};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if (out_valid !== 1'b0 || out_word !== 32'd0) begin
      n_bad++;
      $display("FAIL R1 reset actual=%0b/%08h expected=0/00000000", out_valid, out_word);
    end
    rst_n = 1'b1;
    send(64'h4040266666666666);
    send(64'h0000000000000000);
    send(64'h8000000000000000);
    send(64'h7FF0000000000000);
    send(64'hFFF8000000000001);
    idle(2);
    send(mk(1'b0, 896, 52'hFFFFF_FFFFFFFF));
    send(mk(1'b1, 874, 52'h12345_6789ABCD));
    send(mk(1'b0, 885, 52'hABCDE_F0123456));
    send(mk(1'b1, 897, 52'h00000_20000000));
    send(mk(1'b0, 873, 52'hFFFFF_FFFFFFFF));
    send(mk(1'b1, 0, 52'h00000_00000001));
    idle(1);
    send(mk(1'b0, 900, 52'h55555_55555555));
    idle(3);
    for (int i = 0; i < 400; i++) begin
      logic [63:0] r;
      r = {$urandom, $urandom};
      if (i % 3 == 0) r[62:52] = 11'(874 + ($urandom % 23));
      if (i % 5 == 1) r[62:52] = 11'($urandom % 874);
      if (i % 7 == 2) idle(1 + $urandom % 2);
      send(r);
    end
    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule